// File: doc/BRIEF.md
# OUT Endpoint Chunked Readout Buffer

This block sits between the receive logic of one OUT endpoint and a local processor. Received packets arrive one byte per cycle, with a marker on the final byte of each packet. The bytes are stored in a byte FIFO. The processor does not take a packet in one go. It sees the packet as a sequence of chunks, each at most `CHUNK_BYTES` long. Each chunk is read as little-endian 32-bit words from a single read port.

For the current chunk the block shows a pending flag, an end-of-data flag and a byte count. Once the processor has read every word of the chunk, it acknowledges the chunk with a status-clear strobe. The block then presents the next chunk, or drops pending when nothing is left. If a packet does not fit, the whole packet is discarded and a sticky overflow flag is raised. A software reset empties the buffer and clears every flag.

Top module: `outChunkReader`

## Requirements
- R1: After reset, and after any software reset, the block shows no pending chunk, end-of-data 0, byte count 0 and overflow 0. Once a complete packet is stored, pending rises without any processor action.
- R2: The byte count of a chunk is the smaller of `CHUNK_BYTES` (default 64) and the number of bytes of its packet not yet presented. It never exceeds `CHUNK_BYTES` and reads 0 whenever pending is low.
- R3: End-of-data is set, together with pending, exactly when the current chunk holds the last byte of its packet. Such a chunk either holds fewer than `CHUNK_BYTES` bytes or ends the packet. For every other chunk only pending is set.
- R4: Each read strobe while a chunk is being read returns the next min(4, bytes left in the chunk) bytes. The earliest byte is in bits 7:0, the next in bits 15:8, and so on. Lanes beyond the bytes left read as zero, and a partial word uses up the rest of the chunk.
- R5: Read strobes while no chunk is pending, or after every byte of the chunk has been read, return zero and consume no data.
- R6: Pending, end-of-data and the byte count stay constant until the chunk is fully read and then acknowledged. An acknowledge that comes before the last word has been read is ignored. At the acknowledging clock edge the next chunk is presented, or pending falls if no data remains.
- R7: A packet that would take the stored byte total above `DEPTH_BYTES` (default 512) is dropped whole, and a sticky overflow flag is set. A later packet that fits is accepted, and packets accepted earlier are unaffected.
- R8: At most `PKT_SLOTS` stored packets may wait behind the one being presented. A packet whose last byte arrives when all slots are taken is dropped whole and sets overflow.
- R9: A software reset pulse discards all stored bytes, including a packet that is partly received, and clears pending, end-of-data and overflow in the next cycle.
- R10: Packets are read out in arrival order with their bytes intact, and no chunk ever holds bytes of two packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Received byte valid |
| wrData | input | 8 | Received byte |
| wrLast | input | 1 | Marks the final byte of a packet |
| rdStrobe | input | 1 | One-cycle word read request |
| rdData | output | 32 | Word for the current read, little-endian byte lanes |
| ackStrobe | input | 1 | Status-clear: acknowledges the current chunk |
| swReset | input | 1 | Software FIFO reset |
| pending | output | 1 | Unread chunk is presented |
| endOfData | output | 1 | Presented chunk ends its packet |
| byteCount | output | $clog2(CHUNK_BYTES)+1 (7) | Byte count of the presented chunk |
| overflow | output | 1 | Sticky: a packet was dropped |

## Verification
The bench builds the block with `DEPTH_BYTES=64`, `CHUNK_BYTES=16` and `PKT_SLOTS=4`. With 16-byte chunks, a packet of 33 or 40 bytes splits into three chunks, so chunk boundaries fall inside packets and partial last words stay short. The 64-byte store fills with only two packets, so a packet can be dropped while a byte of room is still free, and a later packet can fill the store exactly. Four slots fill after a handful of one-byte packets, which exercises the dropping of a packet at its last byte.

// File: rtl/outChunkPkg.sv
package outChunkPkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_HELD   = 2'd2
  } chunkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       popLen;     // take the head packet length
    logic       advance;    // move read pointer by advBytes
    logic [2:0] advBytes;   // bytes consumed by this read
    logic [2:0] laneCount;  // valid byte lanes on rdData
    logic       flush;      // software reset
  } dpCmd_t;

endpackage

// File: rtl/outChunkData.sv
module outChunkData
  import outChunkPkg::*;
#(
  parameter int DEPTH_BYTES = 512,
  parameter int PKT_SLOTS   = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrValid,
  input  logic [7:0]                    wrData,
  input  logic                          wrLast,
  input  dpCmd_t                        cmd,
  output logic [31:0]                   rdData,
  output logic                          lenAvail,
  output logic [$clog2(DEPTH_BYTES):0]  lenHead,
  output logic                          overflow
);
  localparam int AW = $clog2(DEPTH_BYTES);
  localparam int LW = AW + 1;
  localparam int SW = $clog2(PKT_SLOTS);

  logic [7:0]    mem [DEPTH_BYTES];
  logic [LW-1:0] lenMem [PKT_SLOTS];

  logic [AW:0]   tentWp, commitWp, rdPtr;
  logic [LW-1:0] pktLen;
  logic          dropping;
  logic [SW:0]   lenWr, lenRd;

  logic [AW:0]   used;
  logic          hasRoom, lenFull, acceptByte, pushLen;
  logic [SW:0]   lenCount;

  always_comb begin
    used       = tentWp - rdPtr;
    hasRoom    = used < (AW+1)'(DEPTH_BYTES);
    lenCount   = lenWr - lenRd;
    lenFull    = lenCount == (SW+1)'(PKT_SLOTS);
    acceptByte = wrValid && !dropping && hasRoom && !(wrLast && lenFull) && !cmd.flush;
    pushLen    = acceptByte && wrLast;
    lenAvail   = lenCount != '0;
    lenHead    = lenMem[lenRd[SW-1:0]];
  end

  // storage arrays carry no reset
  always_ff @(posedge clk) begin
    if (acceptByte) mem[tentWp[AW-1:0]] <= wrData;
    if (pushLen)    lenMem[lenWr[SW-1:0]] <= pktLen + LW'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tentWp   <= '0;
      commitWp <= '0;
      rdPtr    <= '0;
      pktLen   <= '0;
      dropping <= 1'b0;
      lenWr    <= '0;
      lenRd    <= '0;
      overflow <= 1'b0;
    end else if (cmd.flush) begin
      tentWp   <= '0;
      commitWp <= '0;
      rdPtr    <= '0;
      pktLen   <= '0;
      dropping <= 1'b0;
      lenWr    <= '0;
      lenRd    <= '0;
      overflow <= 1'b0;
    end else begin
      if (cmd.advance) rdPtr <= rdPtr + (AW+1)'(cmd.advBytes);
      if (cmd.popLen)  lenRd <= lenRd + (SW+1)'(1);
      if (wrValid) begin
        if (dropping) begin
          if (wrLast) dropping <= 1'b0;
        end else if (!acceptByte) begin
          overflow <= 1'b1;
          tentWp   <= commitWp;
          pktLen   <= '0;
          dropping <= !wrLast;
        end else if (wrLast) begin
          tentWp   <= tentWp + (AW+1)'(1);
          commitWp <= tentWp + (AW+1)'(1);
          pktLen   <= '0;
          lenWr    <= lenWr + (SW+1)'(1);
        end else begin
          tentWp <= tentWp + (AW+1)'(1);
          pktLen <= pktLen + LW'(1);
        end
      end
    end
  end

  // word assembly: lane j is the j-th unread byte
  for (genvar j = 0; j < 4; j++) begin : gLane
    logic [AW-1:0] idx;
    assign idx = rdPtr[AW-1:0] + AW'(j);
    assign rdData[8*j +: 8] = (3'(j) < cmd.laneCount) ? mem[idx] : 8'h00;
  end

endmodule

// File: rtl/outChunkCtrl.sv
module outChunkCtrl
  import outChunkPkg::*;
#(
  parameter int DEPTH_BYTES = 512,
  parameter int CHUNK_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          rdStrobe,
  input  logic                          ackStrobe,
  input  logic                          swReset,
  input  logic                          lenAvail,
  input  logic [$clog2(DEPTH_BYTES):0]  lenHead,
  output dpCmd_t                        cmd,
  output logic                          pending,
  output logic                          endOfData,
  output logic [$clog2(CHUNK_BYTES):0]  byteCount
);
  localparam int LW = $clog2(DEPTH_BYTES) + 1;
  localparam int CW = $clog2(CHUNK_BYTES) + 1;

  chunkState_e   state;
  logic [LW-1:0] pktLeft;
  logic [CW-1:0] chunkSize, chunkLeft;
  logic          endFlag;

  logic [LW-1:0] srcLen;
  logic [CW-1:0] take;
  logic [2:0]    wordBytes;
  logic          haveSrc, loadNow, readNow;

  always_comb begin
    haveSrc   = (pktLeft != '0) || lenAvail;
    srcLen    = (pktLeft != '0) ? pktLeft : lenHead;
    take      = (srcLen > LW'(CHUNK_BYTES)) ? CW'(CHUNK_BYTES) : srcLen[CW-1:0];
    wordBytes = (chunkLeft >= CW'(4)) ? 3'd4 : chunkLeft[2:0];
    loadNow   = !swReset && haveSrc &&
                ((state == ST_IDLE) || (state == ST_HELD && ackStrobe));
    readNow   = !swReset && (state == ST_ACTIVE) && rdStrobe;

    cmd.popLen    = loadNow && (pktLeft == '0);
    cmd.advance   = readNow;
    cmd.advBytes  = wordBytes;
    cmd.laneCount = (state == ST_ACTIVE) ? wordBytes : 3'd0;
    cmd.flush     = swReset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pktLeft   <= '0;
      chunkSize <= '0;
      chunkLeft <= '0;
      endFlag   <= 1'b0;
    end else if (swReset) begin
      state     <= ST_IDLE;
      pktLeft   <= '0;
      chunkSize <= '0;
      chunkLeft <= '0;
      endFlag   <= 1'b0;
    end else if (loadNow) begin
      state     <= ST_ACTIVE;
      chunkSize <= take;
      chunkLeft <= take;
      endFlag   <= srcLen <= LW'(CHUNK_BYTES);
      pktLeft   <= srcLen - LW'(take);
    end else if (state == ST_HELD && ackStrobe) begin
      state   <= ST_IDLE;
      endFlag <= 1'b0;
    end else if (readNow) begin
      chunkLeft <= chunkLeft - CW'(wordBytes);
      if (chunkLeft == CW'(wordBytes)) state <= ST_HELD;
    end
  end

  assign pending   = state != ST_IDLE;
  assign endOfData = pending && endFlag;
  assign byteCount = pending ? chunkSize : '0;

endmodule

// File: rtl/outChunkReader.sv
module outChunkReader
  import outChunkPkg::*;
#(
  parameter int DEPTH_BYTES = 512,
  parameter int CHUNK_BYTES = 64,
  parameter int PKT_SLOTS   = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrValid,
  input  logic [7:0]                    wrData,
  input  logic                          wrLast,
  input  logic                          rdStrobe,
  output logic [31:0]                   rdData,
  input  logic                          ackStrobe,
  input  logic                          swReset,
  output logic                          pending,
  output logic                          endOfData,
  output logic [$clog2(CHUNK_BYTES):0]  byteCount,
  output logic                          overflow
);
  localparam int LW = $clog2(DEPTH_BYTES) + 1;

  dpCmd_t        cmd;
  logic          lenAvail;
  logic [LW-1:0] lenHead;

  outChunkCtrl #(.DEPTH_BYTES(DEPTH_BYTES), .CHUNK_BYTES(CHUNK_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .rdStrobe(rdStrobe), .ackStrobe(ackStrobe),
    .swReset(swReset), .lenAvail(lenAvail), .lenHead(lenHead), .cmd(cmd),
    .pending(pending), .endOfData(endOfData), .byteCount(byteCount)
  );

  outChunkData #(.DEPTH_BYTES(DEPTH_BYTES), .PKT_SLOTS(PKT_SLOTS)) data_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData), .wrLast(wrLast),
    .cmd(cmd), .rdData(rdData), .lenAvail(lenAvail), .lenHead(lenHead),
    .overflow(overflow)
  );

endmodule

// File: rtl/outChunkReader_chk.sv
module outChunkReader_chk #(
  parameter int CHUNK_BYTES = 64
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          ackStrobe,
  input logic                          swReset,
  input logic [31:0]                   rdData,
  input logic                          pending,
  input logic                          endOfData,
  input logic [$clog2(CHUNK_BYTES):0]  byteCount,
  input logic                          overflow
);
  localparam int CW = $clog2(CHUNK_BYTES) + 1;

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    byteCount <= CW'(CHUNK_BYTES));

  assert_count_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !pending |-> byteCount == '0);

  assert_end_needs_pending_R3: assert property (@(posedge clk) disable iff (!rstN)
    endOfData |-> pending);

  assert_idle_data_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    !pending |-> rdData == 32'h0);

  assert_hold_until_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    pending && !ackStrobe && !swReset |=> pending && $stable(byteCount) && $stable(endOfData));

  assert_sticky_overflow_R7: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !swReset |=> overflow);

  assert_sw_reset_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> !pending && !endOfData && !overflow);

endmodule

bind outChunkReader outChunkReader_chk #(.CHUNK_BYTES(CHUNK_BYTES)) chk_i (
  .clk(clk), .rstN(rstN), .ackStrobe(ackStrobe), .swReset(swReset),
  .rdData(rdData), .pending(pending), .endOfData(endOfData),
  .byteCount(byteCount), .overflow(overflow)
);

// File: tb/outChunkReader_tb_top.sv
module outChunkReader_tb_top;
  localparam int DEPTH = 64;
  localparam int CHUNK = 16;
  localparam int SLOTS = 4;
  localparam int CW    = $clog2(CHUNK) + 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrValid = 1'b0, wrLast = 1'b0;
  logic [7:0]    wrData = 8'h0;
  logic          rdStrobe = 1'b0, ackStrobe = 1'b0, swReset = 1'b0;
  logic [31:0]   rdData;
  logic          pending, endOfData, overflow;
  logic [CW-1:0] byteCount;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  outChunkReader #(.DEPTH_BYTES(DEPTH), .CHUNK_BYTES(CHUNK), .PKT_SLOTS(SLOTS)) dut_i (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData), .wrLast(wrLast),
    .rdStrobe(rdStrobe), .rdData(rdData), .ackStrobe(ackStrobe), .swReset(swReset),
    .pending(pending), .endOfData(endOfData), .byteCount(byteCount), .overflow(overflow)
  );

  // stimulus table: packet length and expected number of chunks
  localparam int VEC_N = 7;
  localparam int vecLen    [VEC_N] = '{1, 4, 5, 16, 17, 33, 40};
  localparam int vecChunks [VEC_N] = '{1, 1, 1, 1, 2, 3, 3};

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord(input int seed, input int off, input int n);
    logic [31:0] w = 32'h0;
    for (int k = 0; k < n; k++) w[8*k +: 8] = 8'((seed + off + k) & 255);
    return w;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendPkt(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      wrValid = 1'b1;
      wrData  = 8'((seed + i) & 255);
      wrLast  = (i == len - 1);
    end
    @(negedge clk);
    wrValid = 1'b0;
    wrLast  = 1'b0;
    idle(2);
  endtask

  task automatic readWord(output logic [31:0] w);
    @(negedge clk);
    rdStrobe = 1'b1;
    #1 w = rdData;
    @(posedge clk);
    #1 rdStrobe = 1'b0;
  endtask

  task automatic pulseAck();
    @(negedge clk);
    ackStrobe = 1'b1;
    @(negedge clk);
    ackStrobe = 1'b0;
  endtask

  task automatic pulseSwReset();
    @(negedge clk);
    swReset = 1'b1;
    @(negedge clk);
    swReset = 1'b0;
  endtask

  task automatic drainPacket(input int len, input int seed, input string tag,
                             output int chunks);
    int off = 0;
    logic [31:0] w;
    chunks = 0;
    while (off < len) begin
      int remain = len - off;
      int cnt = (remain > CHUNK) ? CHUNK : remain;
      checkEq("R1", {tag, " pending"}, 32'(pending), 32'd1);
      checkEq("R2", {tag, " byteCount"}, 32'(byteCount), 32'(cnt));
      checkEq("R3", {tag, " endOfData"}, 32'(endOfData), 32'(remain <= CHUNK));
      for (int b = 0; b < cnt; b += 4) begin
        int n = (cnt - b >= 4) ? 4 : cnt - b;
        readWord(w);
        checkEq("R4", {tag, " word"}, w, expWord(seed, off + b, n));
      end
      checkEq("R6", {tag, " held after read"}, 32'(pending), 32'd1);
      pulseAck();
      off += cnt;
      chunks++;
    end
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    int nch;
    logic [31:0] w;
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    checkEq("R1", "reset pending", 32'(pending), 32'd0);
    checkEq("R1", "reset endOfData", 32'(endOfData), 32'd0);
    checkEq("R2", "reset byteCount", 32'(byteCount), 32'd0);
    checkEq("R7", "reset overflow", 32'(overflow), 32'd0);

    // R5 read with nothing pending
    readWord(w);
    checkEq("R5", "idle read data", w, 32'h0);

    // table walk, R10 ordering through successive packets
    for (int v = 0; v < VEC_N; v++) begin
      sendPkt(vecLen[v], 8 * v + 3);
      drainPacket(vecLen[v], 8 * v + 3, "vec", nch);
      checkEq("R10", "vec chunk total", 32'(nch), 32'(vecChunks[v]));
      checkEq("R6", "vec pending after last ack", 32'(pending), 32'd0);
    end

    // R6 early ack ignored, R5 extra read consumes nothing
    sendPkt(20, 8'h40);
    readWord(w);
    checkEq("R4", "early first word", w, expWord(8'h40, 0, 4));
    pulseAck();
    checkEq("R6", "early ack pending", 32'(pending), 32'd1);
    checkEq("R6", "early ack count", 32'(byteCount), 32'(CHUNK));
    for (int b = 4; b < CHUNK; b += 4) begin
      readWord(w);
      checkEq("R4", "early rest word", w, expWord(8'h40, b, 4));
    end
    readWord(w);
    checkEq("R5", "extra read data", w, 32'h0);
    pulseAck();
    checkEq("R2", "tail count", 32'(byteCount), 32'd4);
    checkEq("R3", "tail end", 32'(endOfData), 32'd1);
    readWord(w);
    checkEq("R5", "tail data not consumed", w, expWord(8'h40, 16, 4));
    pulseAck();

    // R10 two packets queued: chunks never span them
    sendPkt(6, 8'h70);
    sendPkt(3, 8'h90);
    drainPacket(6, 8'h70, "pairA", nch);
    drainPacket(3, 8'h90, "pairB", nch);
    checkEq("R10", "pair empty", 32'(pending), 32'd0);

    // R7 overflow: 40 stored, 30 dropped, 24 fills exactly
    sendPkt(40, 8'h11);
    sendPkt(30, 8'h55);
    checkEq("R7", "overflow set", 32'(overflow), 32'd1);
    sendPkt(24, 8'hA0);
    drainPacket(40, 8'h11, "ovA", nch);
    drainPacket(24, 8'hA0, "ovC", nch);
    checkEq("R7", "overflow empty", 32'(pending), 32'd0);
    checkEq("R7", "overflow sticky", 32'(overflow), 32'd1);

    // R9 software reset clears stored data and flags
    sendPkt(8, 8'h20);
    checkEq("R9", "before reset pending", 32'(pending), 32'd1);
    pulseSwReset();
    checkEq("R9", "reset pending", 32'(pending), 32'd0);
    checkEq("R9", "reset endOfData", 32'(endOfData), 32'd0);
    checkEq("R9", "reset overflow", 32'(overflow), 32'd0);
    checkEq("R9", "reset count", 32'(byteCount), 32'd0);
    sendPkt(5, 8'h33);
    drainPacket(5, 8'h33, "postReset", nch);

    // R8 slot limit: one presented + SLOTS queued, sixth dropped
    for (int p = 0; p < SLOTS + 2; p++) begin
      @(negedge clk);
      wrValid = 1'b1;
      wrData  = 8'(16 * p + 1);
      wrLast  = 1'b1;
    end
    @(negedge clk);
    wrValid = 1'b0;
    wrLast  = 1'b0;
    idle(2);
    checkEq("R8", "slot overflow", 32'(overflow), 32'd1);
    for (int p = 0; p < SLOTS + 1; p++) drainPacket(1, 16 * p + 1, "slot", nch);
    checkEq("R8", "slot dropped", 32'(pending), 32'd0);

    report();
  end

endmodule